// File: doc/BRIEF.md
# Buffered-Compare PWM Timer

This block is a 16-bit up-counting timer that produces a single PWM output from two compare values: one sets the period, the other sets the duty. Software programs the block through a small write-only register bus. It sets the active level of the output and the clock divider, writes the two compare values, and then starts counting by setting a run bit.

Compare values never act directly. Each one sits behind a shadow buffer that the counter compares against. The buffers reload only at a counter clear, and only after a write to the duty register has armed the reload. A change of duty therefore needs a single write. A change of period needs a period write followed by a duty write.

When counting stops, the counter returns to zero and the output goes to its inactive level. On the next start, the buffers take the current register values directly. The block also emits a one-cycle pulse at each counter clear and at each duty match, which can serve as interrupt requests.

Top module: `bcpwm_timer`

## Requirements
- R1: Bit 0 of the control register (address 0) is the run bit. Writing 1 starts counting and writing 0 stops it. While stopped, the counter holds at 0, the output sits at its inactive level, and neither pulse output fires.
- R2: The counter counts from 0 up to the buffered period value and then clears to 0 on the next count tick. One period lasts (period+1)·2^k clock cycles. Each clear drives `period_pulse_o` high for one cycle, in the cycle in which the counter reads 0.
- R3: The output is active while the counter is below the buffered duty value. A duty of 0 gives a constantly inactive output. A duty above the period gives a constantly active output.
- R4: Bit 0 of the output register (address 1) selects the active level: 1 means active-high and 0 means active-low. After reset the output is active-high.
- R5: Control bits 3:1 hold k, and the count tick runs at the clock divided by 2^k (k = 0 to 7). k may be written in the same write that sets the run bit, and it then governs the count that follows.
- R6: While counting, writes to the output register are ignored, and so is the k field of a control write. The run bit stays writable.
- R7: A write to the period register (address 2) does not change the running period. The new value takes effect only at a clear that follows a later duty write.
- R8: A write to the duty register (address 3) arms the reload. At the next clear, both buffers take the register values, and the reload then disarms.
- R9: A duty write that falls in the same cycle as a clear does not take part in that clear's reload. It stays armed, and it takes effect at the following clear.
- R10: On a start from the stopped state, both buffers take the current register values, with no duty write needed.
- R11: `match_pulse_o` goes high for one cycle when the counter advances to a value equal to a buffered duty between 1 and the period. It never fires for a duty of 0 or a duty above the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 output, 2 period, 3 duty |
| bus_wdata | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM output pin |
| period_pulse_o | output | 1 | One-cycle pulse on each counter clear |
| match_pulse_o | output | 1 | One-cycle pulse when the counter reaches the duty value |

## Verification
Two events can land on the same clock edge: a software write to the duty register, and the counter clear that performs an armed reload. The bench provokes this by counting cycles from an observed clear pulse. It places a duty write exactly on the edge of the next clear, with no reload armed beforehand. The scoreboard then expects three things: the period ending at that clear keeps the old duty, the period after it also keeps the old duty, and the new duty appears one period later. A design that lets the clear swallow the arm, or that reloads the new value at once, fails one of those windows.

// File: rtl/bcpwm_pkg.sv
// Shared definitions for the buffered-compare PWM timer.
// Holds the register address map and the control field positions.
package bcpwm_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_OUT  = 2'd1,
        ADDR_PER  = 2'd2,
        ADDR_DUTY = 2'd3
    } reg_addr_e;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_SEL_LSB = 1;
    localparam int OUT_LVL_BIT  = 0;

endpackage

// File: rtl/bcpwm_regs.sv
// Register file of the PWM timer.
// Captures bus writes into the run bit, the divider select, the output level
// and the two compare registers.
// Assumes one write per cycle. The divider select and the output level are
// frozen while the run bit is set.
module bcpwm_regs
    import bcpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic             run,
    output logic [SEL_W-1:0] sel,
    output logic             level,
    output logic [CNT_W-1:0] per_reg,
    output logic [CNT_W-1:0] duty_reg,
    output logic             duty_wr
);

    logic wr_ctrl, wr_out, wr_per;

    // Decode the write target.
    always_comb begin
        wr_ctrl = wr && (reg_addr_e'(addr) == ADDR_CTRL);
        wr_out  = wr && (reg_addr_e'(addr) == ADDR_OUT);
        wr_per  = wr && (reg_addr_e'(addr) == ADDR_PER);
        duty_wr = wr && (reg_addr_e'(addr) == ADDR_DUTY);
    end

    // Control and output registers; mode fields accept writes only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            sel   <= '0;
            level <= 1'b1;
        end else begin
            if (wr_ctrl) begin
                run <= wdata[CTRL_RUN_BIT];
                if (!run) sel <= wdata[CTRL_SEL_LSB +: SEL_W];
            end
            if (wr_out && !run) level <= wdata[OUT_LVL_BIT];
        end
    end

    // Compare registers, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_reg  <= '0;
            duty_reg <= '0;
        end else begin
            if (wr_per)  per_reg  <= wdata;
            if (duty_wr) duty_reg <= wdata;
        end
    end

    // R6: the divider select holds across cycles in which the block keeps running.
    a_r6_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (!run || $stable(sel)));

    // R6: the output level holds across cycles in which the block keeps running.
    a_r6_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (!run || $stable(level)));

endmodule

// File: rtl/bcpwm_prescaler.sv
// Clock divider for the PWM timer.
// Produces a one-cycle count tick every 2^sel cycles while running.
// Assumes sel changes only while stopped; the phase restarts at each start.
module bcpwm_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int DIV_W = (1 << SEL_W) - 1;
    localparam logic [DIV_W-1:0] ONE = 1;

    logic [DIV_W-1:0] pre_cnt;
    logic [DIV_W-1:0] mask;

    // Low-bit mask with sel ones selects the divide ratio.
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (int'(sel) > i);
    end

    // Free-running phase counter, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_cnt <= '0;
        else                pre_cnt <= pre_cnt + ONE;
    end

    // A tick fires when every masked bit of the phase is one.
    always_comb tick = run && ((pre_cnt & mask) == mask);

endmodule

// File: rtl/bcpwm_buffers.sv
// Shadow buffers for the period and duty compare values.
// While stopped the buffers follow the registers. While running they reload
// only at a clear, and only when a duty write has armed them. A duty write in
// the clear cycle re-arms the buffers for the next clear.
module bcpwm_buffers #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] per_reg,
    input  logic [CNT_W-1:0] duty_reg,
    output logic [CNT_W-1:0] per_buf,
    output logic [CNT_W-1:0] duty_buf
);

    logic armed;
    logic reload;

    // An armed clear triggers a reload.
    always_comb reload = clr && armed;

    // Buffer contents: track while stopped, reload on an armed clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_buf  <= '0;
            duty_buf <= '0;
        end else if (!run || reload) begin
            per_buf  <= per_reg;
            duty_buf <= duty_reg;
        end
    end

    // Arm flag: set by a duty write, cleared by the reload it served.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) armed <= 1'b0;
        else if (duty_wr)   armed <= 1'b1;
        else if (clr)       armed <= 1'b0;
    end

    // R7: buffers stay put while running, except across an armed clear.
    a_r7_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !reload) |=> ($stable(per_buf) && $stable(duty_buf)));

    // R8: after an armed clear the buffers hold what the registers held.
    a_r8_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (run && reload) |=> (per_buf == $past(per_reg) && duty_buf == $past(duty_reg)));

endmodule

// File: rtl/bcpwm_counter.sv
// Period counter and compare logic.
// Counts on each tick from 0 to the buffered period, then clears.
// Flags the clear event, a step onto the duty value, and the active phase.
module bcpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_buf,
    input  logic [CNT_W-1:0] duty_buf,
    output logic [CNT_W-1:0] cnt,
    output logic             clr,
    output logic             match_evt,
    output logic             active
);

    localparam logic [CNT_W-1:0] ONE = 1;

    logic [CNT_W-1:0] cnt_inc;

    // Events seen by the current tick.
    always_comb begin
        cnt_inc   = cnt + ONE;
        clr       = tick && (cnt == per_buf);
        match_evt = tick && !clr && (cnt_inc == duty_buf);
        active    = run && (cnt < duty_buf);
    end

    // Counter register: hold at zero while stopped, wrap at the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (clr)       cnt <= '0;
        else if (tick)      cnt <= cnt_inc;
    end

    // R2: the counter never passes the buffered period.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_buf);

    // R1: a stopped timer keeps its counter at zero.
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/bcpwm_timer.sv
// Top of the buffered-compare PWM timer.
// Joins the register file, the divider, the shadow buffers and the counter.
// Drives the PWM pin at the chosen active level, and registers the clear and
// match events into one-cycle pulses.
module bcpwm_timer #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic             pwm_o,
    output logic             period_pulse_o,
    output logic             match_pulse_o
);

    logic             run, level, duty_wr, tick, clr, match_evt, active;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] per_reg, duty_reg, per_buf, duty_buf, cnt;

    bcpwm_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .run(run), .sel(sel), .level(level), .per_reg(per_reg),
        .duty_reg(duty_reg), .duty_wr(duty_wr)
    );

    bcpwm_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .tick(tick)
    );

    bcpwm_buffers #(.CNT_W(CNT_W)) u_bufs (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .duty_wr(duty_wr),
        .per_reg(per_reg), .duty_reg(duty_reg), .per_buf(per_buf), .duty_buf(duty_buf)
    );

    bcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .per_buf(per_buf),
        .duty_buf(duty_buf), .cnt(cnt), .clr(clr), .match_evt(match_evt), .active(active)
    );

    // Output pin at the selected active level.
    always_comb pwm_o = level ? active : !active;

    // Event pulses registered to one clean cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_pulse_o <= 1'b0;
            match_pulse_o  <= 1'b0;
        end else begin
            period_pulse_o <= clr;
            match_pulse_o  <= match_evt;
        end
    end

    // R1: a stopped timer shows the inactive level on the pin.
    a_r1_idle_output: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_o == !level));

    // R2: the clear pulse coincides with a zero count.
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        period_pulse_o |-> (cnt == '0));

    // R11: a match pulse sits on the duty value and never on a zero duty.
    a_r11_match_value: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse_o |-> (cnt == duty_buf && duty_buf != '0));

endmodule

// File: tb/bcpwm_timer_tb.sv
// Scoreboard bench: the driver queues expected period windows, and the
// monitor measures windows between clear pulses and compares them.
module bcpwm_timer_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = '0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic             pwm_o, period_pulse_o, match_pulse_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int    q_len[$];
    int    q_hi[$];
    int    q_mt[$];
    string q_tag[$];

    always #10 clk = ~clk;

    bcpwm_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pwm_o(pwm_o), .period_pulse_o(period_pulse_o),
        .match_pulse_o(match_pulse_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = CNT_W'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push_exp(input int len, input int hi, input int mt, input string tag);
        q_len.push_back(len); q_hi.push_back(hi); q_mt.push_back(mt); q_tag.push_back(tag);
    endtask

    task automatic drain();
        while (q_len.size() != 0) @(posedge clk);
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!period_pulse_o);
    endtask

    // Monitor: measures each window between clear pulses and scores it.
    bit started = 1'b0;
    int m_len = 0, m_hi = 0, m_mt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (period_pulse_o) begin
                if (started && q_len.size() != 0) begin
                    chk(m_len == q_len[0], {q_tag[0], " period length"}, m_len, q_len[0]);
                    chk(m_hi  == q_hi[0],  {q_tag[0], " high cycles"},   m_hi,  q_hi[0]);
                    chk(m_mt  == q_mt[0],  {q_tag[0], " match pulses"},  m_mt,  q_mt[0]);
                    void'(q_len.pop_front()); void'(q_hi.pop_front());
                    void'(q_mt.pop_front());  void'(q_tag.pop_front());
                end
                started = (q_len.size() != 0);
                m_len = 0; m_hi = 0; m_mt = 0;
            end
            m_len += 1;
            m_hi  += int'(pwm_o);
            m_mt  += int'(match_pulse_o);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R4: reset state is stopped and active-high, so the pin is low.
        chk(pwm_o == 1'b0, "R1 reset pin", int'(pwm_o), 0);
        chk(period_pulse_o == 1'b0 && match_pulse_o == 1'b0, "R1 reset pulses",
            int'(period_pulse_o) + int'(match_pulse_o), 0);

        // R10/R2/R3/R11: program while stopped, then start with k=0.
        bus_write(2'd2, 9);
        bus_write(2'd3, 3);
        bus_write(2'd1, 1);
        bus_write(2'd0, 1);
        push_exp(10, 3, 1, "R10 R2 R3 R11 start");
        drain();

        // R8: a duty write alone changes the duty.
        bus_write(2'd3, 7);
        push_exp(10, 7, 1, "R8 duty only");
        drain();

        // R7: a period write alone leaves the running period.
        bus_write(2'd2, 19);
        push_exp(10, 7, 1, "R7 period not applied");
        drain();
        bus_write(2'd3, 7);
        push_exp(20, 7, 1, "R7 period after duty write");
        drain();

        bus_write(2'd3, 5);
        push_exp(20, 5, 1, "R8 duty 5");
        drain();

        // R9: a duty write on the clear edge takes effect one clear later.
        push_exp(20, 5, 1, "R9 before coincident write");
        push_exp(20, 5, 1, "R9 period after coincident clear");
        push_exp(20, 12, 1, "R9 following period");
        wait_pulse();
        repeat (19) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = CNT_W'(12);
        @(negedge clk);
        bus_wr = 1'b0;
        drain();

        // R6: level and divider writes while running are ignored.
        bus_write(2'd1, 0);
        bus_write(2'd0, 7);
        push_exp(20, 12, 1, "R6 ignored mode writes");
        drain();

        // R3/R11: zero duty and a duty above the period.
        bus_write(2'd3, 0);
        push_exp(20, 0, 0, "R3 R11 duty zero");
        drain();
        bus_write(2'd3, 25);
        push_exp(20, 20, 0, "R3 R11 duty above period");
        drain();

        // R1: stopping forces the inactive level and silences the pulses.
        bus_write(2'd0, 0);
        chk(pwm_o == 1'b0, "R1 stop pin", int'(pwm_o), 0);
        begin
            int bad = 0;
            repeat (30) begin
                @(negedge clk);
                if (pwm_o || period_pulse_o || match_pulse_o) bad++;
            end
            chk(bad == 0, "R1 stopped quiet", bad, 0);
        end

        // R4: active-low while stopped shows a high pin.
        bus_write(2'd1, 0);
        chk(pwm_o == 1'b1, "R4 active-low idle", int'(pwm_o), 1);

        // R10/R5/R4: new compares load at start; k=2 set with the run bit.
        bus_write(2'd3, 2);
        bus_write(2'd2, 7);
        bus_write(2'd0, (2 << 1) | 1);
        push_exp(32, 32 - 8, 1, "R5 R4 R10 divided restart");
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule